// File: doc/BRIEF.md
# Raster Panel Timing Generator

This block drives a raster display panel from a single module clock. It divides the module clock to make a pixel clock and walks two counters. The horizontal counter steps once per pixel. The vertical counter steps once per line. From these counters it produces a horizontal sync, a vertical sync, a combined strobe and a 16-bit pixel bus. The strobe serves either as a data-enable or as a slow AC-bias toggle.

Each line and each frame has four segments, always in this order: sync pulse, back porch, active region and front porch. Software sets the length of each segment through a field that holds the length minus one, so a field of zero gives one pixel or one line. Pixels come from an upstream source over a ready/valid handshake in raster order. HSYNC and pixel data change together with the rising edge of the pixel clock. VSYNC and the strobe change together with the falling edge.

Top module: `lcd_raster_timer`

## Requirements
- R1: With a divider setting N of 2 or more, `pclk_o` is high for floor(N/2) module clocks and low for the remaining N-floor(N/2). A setting below 2 behaves as 2.
- R2: `hsync_o` and `data_o` change only in the module clock in which `pclk_o` rises. `vsync_o` and `bias_o` change only in the module clock in which `pclk_o` falls.
- R3: A line lasts (h_sync+1)+(h_back+1)+(h_active+1)+(h_front+1) pixel clocks. `hsync_o` is high (active-high) for h_sync+1 of them, and a rising `hsync_o` marks each new line.
- R4: A frame lasts (v_sync+1)+(v_back+1)+(v_active+1)+(v_front+1) lines. `vsync_o` is high (active-high) for v_sync+1 line starts, and a rising `vsync_o` marks each new frame.
- R5: With `bias_mode`=0, `bias_o` is a data-enable. It is high for exactly h_active+1 pixel clocks in each active line, low for the whole of every other line, and high for (h_active+1)*(v_active+1) pixels in a frame.
- R6: `pix_ready` is high for one module clock per active pixel, (h_active+1)*(v_active+1) times per frame. A pixel is taken when `pix_ready` and `pix_valid` are both high. The pixels appear on `data_o` in the order taken, each while the data-enable is high, and `data_o` is zero outside the active pixels.
- R7: If `pix_valid` is low when `pix_ready` is high, that pixel is shown as zero and `underflow_o` goes high. It stays high until `enable` is dropped, and it stays low while the source is always valid.
- R8: With `bias_mode`=1, `bias_o` toggles once every bias_lines+1 lines.
- R9: While `enable` is low, `pclk_o`, `hsync_o`, `vsync_o`, `bias_o`, `data_o`, `pix_ready` and `underflow_o` are all zero. After `enable` rises, the vertical sync comes before any active pixel.
- R10: While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run; low clears all counters and outputs |
| div_ratio | input | 8 | Module clocks per pixel clock (values below 2 act as 2) |
| h_sync | input | 10 | Horizontal sync width minus one, in pixels |
| h_back | input | 10 | Horizontal back porch minus one |
| h_active | input | 10 | Pixels per line minus one |
| h_front | input | 10 | Horizontal front porch minus one |
| v_sync | input | 10 | Vertical sync width minus one, in lines |
| v_back | input | 10 | Vertical back porch minus one |
| v_active | input | 10 | Active lines minus one |
| v_front | input | 10 | Vertical front porch minus one |
| bias_lines | input | 8 | Lines per AC-bias half period minus one |
| bias_mode | input | 1 | 0: `bias_o` is data-enable, 1: `bias_o` is the AC-bias toggle |
| pix_valid | input | 1 | Source has a pixel |
| pix_data | input | 16 | Pixel from the source |
| pix_ready | output | 1 | Block takes a pixel this clock |
| pclk_o | output | 1 | Pixel clock |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| bias_o | output | 1 | Data-enable or AC-bias strobe |
| data_o | output | 16 | Pixel bus |
| underflow_o | output | 1 | Sticky flag: a pixel was needed but not valid |

## Verification
The timing is tried with a mid-size setting (divider 4), with a setting where every field is zero and the divider is 1, and with an odd divider of 5. These separate the minus-one field encoding, the clamp of the divider to 2, and the unequal high and low halves of the pixel clock. Random settings of all fields and both strobe modes follow, with a source whose valid flag is random. This shows whether the line, frame, enable and toggle counts stay right across segment lengths, and whether the data order holds when pixels are skipped. A run with the source held invalid and then valid again separates zero-fill and a sticky flag from a flag that clears by itself. Stopping and restarting shows that a frame restarts with its sync segment.

// File: rtl/lcdrt_pkg.sv
package lcdrt_pkg;
   // segment order inside a line or a frame; the sequencer walks it upward
   typedef enum logic [1:0] {
      SEG_SYNC   = 2'd0,
      SEG_BACK   = 2'd1,
      SEG_ACTIVE = 2'd2,
      SEG_FRONT  = 2'd3
   } lcdrt_seg_e;

   localparam int unsigned LCDRT_SEGS = 4;
endpackage

// File: rtl/lcdrt_clkdiv.sv
module lcdrt_clkdiv #(
   parameter int unsigned DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div_ratio,
   output logic             pclk,
   output logic             rise_ev,
   output logic             fall_ev
);
   localparam logic [DIV_W-1:0] MIN_RATIO = DIV_W'(2);

   if (DIV_W < 2) begin : g_bad_div_w
      $error("lcdrt_clkdiv: DIV_W must hold the value 2");
   end

   logic [DIV_W-1:0] ratio_eff, half_m1, last_cnt, cnt;

   assign ratio_eff = (div_ratio < MIN_RATIO) ? MIN_RATIO : div_ratio;
   assign half_m1   = (ratio_eff >> 1) - DIV_W'(1);
   assign last_cnt  = ratio_eff - DIV_W'(1);
   assign rise_ev   = run && (cnt >= last_cnt);
   assign fall_ev   = run && (cnt == half_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         pclk <= 1'b0;
      end else if (!run) begin
         cnt  <= '0;
         pclk <= 1'b0;
      end else begin
         cnt <= rise_ev ? '0 : cnt + DIV_W'(1);
         if (rise_ev)      pclk <= 1'b1;
         else if (fall_ev) pclk <= 1'b0;
      end
   end

   a_r1_rise_drives_high: assert property (@(posedge clk) disable iff (!rst_n)
      rise_ev |=> pclk);
   a_r1_fall_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
      fall_ev |=> !pclk);
   a_r1_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !rise_ev && !fall_ev) |=> $stable(pclk));
endmodule

// File: rtl/lcdrt_seg_seq.sv
module lcdrt_seg_seq
   import lcdrt_pkg::*;
#(
   parameter int unsigned CNT_W = 10
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             clr,
   input  logic                             step,
   input  logic [LCDRT_SEGS-1:0][CNT_W-1:0] seg_len,
   output lcdrt_seg_e                       seg,
   output logic                             period_last
);
   if (CNT_W < 1) begin : g_bad_cnt_w
      $error("lcdrt_seg_seq: CNT_W must be at least 1");
   end

   logic [CNT_W-1:0] cnt;
   logic [1:0]       seg_idx;
   logic             seg_last;

   assign seg_idx     = seg;
   assign seg_last    = (cnt >= seg_len[seg_idx]);
   assign period_last = seg_last && (seg == SEG_FRONT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         seg <= SEG_SYNC;
      end else if (clr) begin
         cnt <= '0;
         seg <= SEG_SYNC;
      end else if (step) begin
         if (seg_last) begin
            cnt <= '0;
            seg <= lcdrt_seg_e'(seg_idx + 2'd1);
         end else begin
            cnt <= cnt + CNT_W'(1);
         end
      end
   end

   a_r3_wrap_to_sync: assert property (@(posedge clk) disable iff (!rst_n)
      (step && period_last && !clr) |=> (seg == SEG_SYNC));
   a_r9_clear_to_sync: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (seg == SEG_SYNC));
endmodule

// File: rtl/lcdrt_bias_tgl.sv
module lcdrt_bias_tgl #(
   parameter int unsigned LN_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            line_end,
   input  logic [LN_W-1:0] period,
   output logic            flip
);
   if (LN_W < 1) begin : g_bad_ln_w
      $error("lcdrt_bias_tgl: LN_W must be at least 1");
   end

   logic [LN_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         flip <= 1'b0;
      end else if (clr) begin
         cnt  <= '0;
         flip <= 1'b0;
      end else if (line_end) begin
         if (cnt >= period) begin
            cnt  <= '0;
            flip <= !flip;
         end else begin
            cnt <= cnt + LN_W'(1);
         end
      end
   end

   a_r8_flip_only_on_line_end: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !line_end) |=> $stable(flip));
endmodule

// File: rtl/lcd_raster_timer.sv
module lcd_raster_timer
   import lcdrt_pkg::*;
#(
   parameter int unsigned DIV_W  = 8,
   parameter int unsigned H_W    = 10,
   parameter int unsigned V_W    = 10,
   parameter int unsigned BIAS_W = 8,
   parameter int unsigned PIX_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [DIV_W-1:0]  div_ratio,
   input  logic [H_W-1:0]    h_sync,
   input  logic [H_W-1:0]    h_back,
   input  logic [H_W-1:0]    h_active,
   input  logic [H_W-1:0]    h_front,
   input  logic [V_W-1:0]    v_sync,
   input  logic [V_W-1:0]    v_back,
   input  logic [V_W-1:0]    v_active,
   input  logic [V_W-1:0]    v_front,
   input  logic [BIAS_W-1:0] bias_lines,
   input  logic              bias_mode,
   input  logic              pix_valid,
   input  logic [PIX_W-1:0]  pix_data,
   output logic              pix_ready,
   output logic              pclk_o,
   output logic              hsync_o,
   output logic              vsync_o,
   output logic              bias_o,
   output logic [PIX_W-1:0]  data_o,
   output logic              underflow_o
);
   if (PIX_W < 1) begin : g_bad_pix_w
      $error("lcd_raster_timer: PIX_W must be at least 1");
   end

   logic rise_ev, fall_ev;
   logic h_last, v_last_unused, line_end, act, flip;
   logic vs_cap, act_cap;
   lcdrt_seg_e h_seg, v_seg;
   logic [LCDRT_SEGS-1:0][H_W-1:0] h_len;
   logic [LCDRT_SEGS-1:0][V_W-1:0] v_len;

   assign h_len = {h_front, h_active, h_back, h_sync};
   assign v_len = {v_front, v_active, v_back, v_sync};

   lcdrt_clkdiv #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .run(enable), .div_ratio(div_ratio),
      .pclk(pclk_o), .rise_ev(rise_ev), .fall_ev(fall_ev));

   lcdrt_seg_seq #(.CNT_W(H_W)) u_hseq (
      .clk(clk), .rst_n(rst_n), .clr(!enable), .step(rise_ev),
      .seg_len(h_len), .seg(h_seg), .period_last(h_last));

   assign line_end = rise_ev && h_last;

   lcdrt_seg_seq #(.CNT_W(V_W)) u_vseq (
      .clk(clk), .rst_n(rst_n), .clr(!enable), .step(line_end),
      .seg_len(v_len), .seg(v_seg), .period_last(v_last_unused));

   lcdrt_bias_tgl #(.LN_W(BIAS_W)) u_bias (
      .clk(clk), .rst_n(rst_n), .clr(!enable), .line_end(line_end),
      .period(bias_lines), .flip(flip));

   assign act       = (h_seg == SEG_ACTIVE) && (v_seg == SEG_ACTIVE);
   assign pix_ready = rise_ev && act;

   // rising-edge launch: hsync and pixel; falling-edge launch: vsync and strobe
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hsync_o     <= 1'b0;
         vsync_o     <= 1'b0;
         bias_o      <= 1'b0;
         data_o      <= '0;
         vs_cap      <= 1'b0;
         act_cap     <= 1'b0;
         underflow_o <= 1'b0;
      end else if (!enable) begin
         hsync_o     <= 1'b0;
         vsync_o     <= 1'b0;
         bias_o      <= 1'b0;
         data_o      <= '0;
         vs_cap      <= 1'b0;
         act_cap     <= 1'b0;
         underflow_o <= 1'b0;
      end else begin
         if (rise_ev) begin
            hsync_o <= (h_seg == SEG_SYNC);
            vs_cap  <= (v_seg == SEG_SYNC);
            act_cap <= act;
            data_o  <= (act && pix_valid) ? pix_data : '0;
            if (act && !pix_valid) underflow_o <= 1'b1;
         end
         if (fall_ev) begin
            vsync_o <= vs_cap;
            bias_o  <= bias_mode ? flip : act_cap;
         end
      end
   end

   a_r2_hsync_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && $past(enable) && !$stable(hsync_o)) |-> $rose(pclk_o));
   a_r2_data_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && $past(enable) && !$stable(data_o)) |-> $rose(pclk_o));
   a_r2_vsync_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && $past(enable) && !$stable(vsync_o)) |-> $fell(pclk_o));
   a_r2_bias_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && $past(enable) && !$stable(bias_o)) |-> $fell(pclk_o));
   a_r6_take_with_rise: assert property (@(posedge clk) disable iff (!rst_n)
      pix_ready |=> $rose(pclk_o));
   a_r7_underflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && underflow_o) |=> underflow_o);
   a_r9_idle_outputs: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!pclk_o && !hsync_o && !vsync_o && !bias_o && (data_o == '0) && !underflow_o));
endmodule

// File: tb/lcd_raster_timer_test.sv
module lcd_raster_timer_test;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic [7:0]  div_ratio = 8'd4;
   logic [9:0]  h_sync = '0, h_back = '0, h_active = '0, h_front = '0;
   logic [9:0]  v_sync = '0, v_back = '0, v_active = '0, v_front = '0;
   logic [7:0]  bias_lines = '0;
   logic        bias_mode = 1'b0;
   logic        pix_valid = 1'b1;
   logic [15:0] pix_data;
   logic        pix_ready, pclk_o, hsync_o, vsync_o, bias_o, underflow_o;
   logic [15:0] data_o;

   always #(CLK_P/2) clk = ~clk;

   lcd_raster_timer uut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .div_ratio(div_ratio),
      .h_sync(h_sync), .h_back(h_back), .h_active(h_active), .h_front(h_front),
      .v_sync(v_sync), .v_back(v_back), .v_active(v_active), .v_front(v_front),
      .bias_lines(bias_lines), .bias_mode(bias_mode),
      .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready),
      .pclk_o(pclk_o), .hsync_o(hsync_o), .vsync_o(vsync_o), .bias_o(bias_o),
      .data_o(data_o), .underflow_o(underflow_o));

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int ratio_eff();
      return (div_ratio < 2) ? 2 : int'(div_ratio);
   endfunction
   function automatic int exp_hi();  return ratio_eff() / 2; endfunction
   function automatic int exp_lo();  return ratio_eff() - exp_hi(); endfunction
   function automatic int htot();
      return int'(h_sync) + int'(h_back) + int'(h_active) + int'(h_front) + 4;
   endfunction
   function automatic int vtot();
      return int'(v_sync) + int'(v_back) + int'(v_active) + int'(v_front) + 4;
   endfunction
   function automatic int frame_pix();
      return (int'(h_active) + 1) * (int'(v_active) + 1);
   endfunction

   // pixel source and expected-pixel queue
   logic [15:0] src = 16'd1;
   logic [15:0] exp_q[$];
   assign pix_data = src;

   always @(posedge clk) begin
      if (!rst_n || !enable || bias_mode) exp_q.delete();
      else if (pix_ready) exp_q.push_back(pix_valid ? pix_data : 16'd0);
      if (!rst_n) src <= 16'd1;
      else if (pix_ready && pix_valid) src <= src + 16'd1;
   end

   // monitor
   logic p_pclk = 0, p_hs = 0, p_vs = 0, p_bias = 0;
   logic [15:0] p_data = '0;
   int hi_run, lo_run, pix_line, hs_px, de_line, de_frame, lines, vs_lines, rdy_frame, acb_lines;
   bit hi_ok, lo_ok, line_ok, frame_ok, acb_ok, pend;

   always @(negedge clk) begin
      if (!rst_n || !enable) begin
         hi_run = 0; lo_run = 0; pix_line = 0; hs_px = 0; de_line = 0; de_frame = 0;
         lines = 0; vs_lines = 0; rdy_frame = 0; acb_lines = 0;
         hi_ok = 0; lo_ok = 0; line_ok = 0; frame_ok = 0; acb_ok = 0; pend = 1;
      end else begin
         automatic bit rise = pclk_o && !p_pclk;
         automatic bit fall = !pclk_o && p_pclk;
         // R1 pixel clock shape
         if (rise) begin
            if (lo_ok) chk(lo_run == exp_lo(), "R1 pclk low time", lo_run, exp_lo());
            hi_run = 1; hi_ok = 1;
         end else if (pclk_o) hi_run++;
         if (fall) begin
            if (hi_ok) chk(hi_run == exp_hi(), "R1 pclk high time", hi_run, exp_hi());
            lo_run = 1; lo_ok = 1;
         end else if (!pclk_o) lo_run++;
         // R2 launch edges
         if (hsync_o != p_hs)  chk(rise, "R2 hsync moves on rise", fall, 0);
         if (data_o != p_data) chk(rise, "R2 data moves on rise", fall, 0);
         if (vsync_o != p_vs)  chk(fall, "R2 vsync moves on fall", rise, 0);
         if (bias_o != p_bias) chk(fall, "R2 bias moves on fall", rise, 0);
         if (pix_ready) rdy_frame++;
         // R3 line timing
         if (hsync_o && !p_hs) begin
            if (line_ok) begin
               chk(pix_line == htot(), "R3 line length", pix_line, htot());
               chk(hs_px == int'(h_sync) + 1, "R3 hsync width", hs_px, int'(h_sync) + 1);
               if (!bias_mode)
                  chk(de_line == 0 || de_line == int'(h_active) + 1, "R5 enable per line",
                      de_line, int'(h_active) + 1);
            end
            line_ok = 1; pix_line = 0; hs_px = 0; de_line = 0;
            lines++; acb_lines++;
            if (vsync_o) vs_lines++;
         end
         if (rise) begin
            pix_line++;
            if (hsync_o) hs_px++;
         end
         // R4 frame timing
         if (vsync_o && !p_vs) begin
            if (frame_ok) begin
               chk(lines == vtot(), "R4 frame lines", lines, vtot());
               chk(vs_lines == int'(v_sync) + 1, "R4 vsync width", vs_lines, int'(v_sync) + 1);
               if (!bias_mode) chk(de_frame == frame_pix(), "R5 enable per frame", de_frame, frame_pix());
               chk(rdy_frame == frame_pix(), "R6 ready per frame", rdy_frame, frame_pix());
            end
            frame_ok = 1; lines = 0; vs_lines = 0; de_frame = 0; rdy_frame = 0;
         end
         // R5/R6 data-enable mode pixel stream
         if (fall && !bias_mode) begin
            if (bias_o) begin
               de_line++; de_frame++;
               if (exp_q.size() == 0) chk(0, "R6 pixel without take", data_o, 0);
               else begin
                  automatic logic [15:0] e = exp_q.pop_front();
                  chk(data_o == e, "R6 pixel order", data_o, e);
               end
            end else chk(data_o == 16'd0, "R6 blank data zero", data_o, 0);
         end
         // R8 AC-bias toggle period
         if (bias_mode && bias_o != p_bias) begin
            if (acb_ok) chk(acb_lines == int'(bias_lines) + 1, "R8 bias toggle period",
                            acb_lines, int'(bias_lines) + 1);
            acb_ok = 1; acb_lines = 0;
         end
         // R9 restart with vertical sync
         if (pend && !bias_mode && (vsync_o || bias_o)) begin
            chk(vsync_o, "R9 frame restarts with vsync", bias_o, 0);
            pend = 0;
         end
      end
      p_pclk = pclk_o; p_hs = hsync_o; p_vs = vsync_o; p_bias = bias_o; p_data = data_o;
   end

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic set_cfg(input int r, input int hs, input int hb, input int ha, input int hf,
                          input int vs, input int vb, input int va, input int vf,
                          input int bl, input bit md);
      div_ratio = 8'(r);
      h_sync = 10'(hs); h_back = 10'(hb); h_active = 10'(ha); h_front = 10'(hf);
      v_sync = 10'(vs); v_back = 10'(vb); v_active = 10'(va); v_front = 10'(vf);
      bias_lines = 8'(bl); bias_mode = md;
   endtask

   task automatic run(input int frames, input bit rnd);
      enable = 1'b1;
      repeat (frames * htot() * vtot() * ratio_eff() + 2 * htot() * ratio_eff()) begin
         tick();
         if (rnd) pix_valid = ($urandom % 8) != 0;
      end
   endtask

   task automatic stop_and_check();
      enable = 1'b0;
      repeat (4) tick();
      chk(!pclk_o,      "R9 idle pclk", pclk_o, 0);
      chk(!hsync_o,     "R9 idle hsync", hsync_o, 0);
      chk(!vsync_o,     "R9 idle vsync", vsync_o, 0);
      chk(!bias_o,      "R9 idle bias", bias_o, 0);
      chk(data_o == 0,  "R9 idle data", data_o, 0);
      chk(!pix_ready,   "R9 idle ready", pix_ready, 0);
      chk(!underflow_o, "R9 idle underflow cleared", underflow_o, 0);
      pix_valid = 1'b1;
   endtask

   task automatic summary();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
   endtask

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (5) tick();
      // R10 reset state
      chk(!pclk_o && !hsync_o && !vsync_o, "R10 reset timing outputs", {pclk_o, hsync_o, vsync_o}, 0);
      chk(!bias_o && !pix_ready && !underflow_o, "R10 reset strobes", {bias_o, pix_ready, underflow_o}, 0);
      chk(data_o == 0, "R10 reset data", data_o, 0);
      rst_n = 1'b1;
      repeat (3) tick();

      // directed: mid-size timing, source always valid
      set_cfg(4, 1, 2, 7, 1, 1, 1, 3, 1, 0, 1'b0);
      run(3, 1'b0);
      chk(!underflow_o, "R7 no underflow when fed", underflow_o, 0);
      // starve the panel for a frame, then feed again
      pix_valid = 1'b0;
      run(1, 1'b0);
      chk(underflow_o, "R7 underflow raised", underflow_o, 1);
      pix_valid = 1'b1;
      run(1, 1'b0);
      chk(underflow_o, "R7 underflow sticky", underflow_o, 1);
      stop_and_check();

      // directed: divider clamp and every field at zero
      set_cfg(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1'b0);
      run(4, 1'b0);
      stop_and_check();

      // directed: odd divider, AC-bias mode
      set_cfg(5, 2, 1, 5, 3, 0, 2, 2, 1, 2, 1'b1);
      run(4, 1'b0);
      stop_and_check();

      // random settings with a sometimes-idle source
      for (int it = 0; it < 8; it++) begin
         set_cfg($urandom_range(6, 1), $urandom_range(3, 0), $urandom_range(3, 0),
                 $urandom_range(7, 0), $urandom_range(3, 0), $urandom_range(3, 0),
                 $urandom_range(3, 0), $urandom_range(3, 0), $urandom_range(3, 0),
                 $urandom_range(3, 0), 1'($urandom % 2));
         run(3, 1'b1);
         stop_and_check();
      end

      done = 1;
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         summary();
         $finish;
      end
   end
endmodule